// File: doc/BRIEF.md
# Quadword Multiply-by-Ten Unit

This block scales a 128-bit unsigned integer by ten in one registered step. It is used when a wide binary value has to be shifted up by one decimal digit. For that use it can fold in a decimal digit as a carry-in. It can also return the digit that spills out above the 128-bit width, instead of the truncated product. The product is built from two shifted copies of the operand, (A<<3)+(A<<1). The work is split into equal slices, and a 4-bit decimal carry ripples from each slice into the one above it.

Two mode pins pick the behaviour. `in_ext` adds the carry-in digit, which is taken from the low nibble of `in_b`. `in_carry` returns the overflow digit instead of the product. A digit above nine has no meaningful result, so it is replaced by zero. The result appears on a registered output one clock after `in_valid`, together with `out_valid`.

Top module: `qmt_mul10`

## Requirements
- R1: With in_ext=0 and in_carry=0, out_data equals bits 127:0 of in_a×10.
- R2: With in_ext=1, the carry-in digit is in_b[3:0] when that value is 0 to 9, and it is added to in_a×10 at bit 0.
- R3: With in_ext=1 and in_b[3:0] in the range 10 to 15, the carry-in is treated as 0.
- R4: With in_carry=1, out_data[3:0] holds bits 131:128 of the 132-bit value in_a×10+cin, and out_data[127:4] is zero.
- R5: With in_carry=1, the carry digit never exceeds 9.
- R6: With in_ext=0, in_b has no effect on out_data and the carry-in is 0.
- R7: out_valid is high exactly one clock after a cycle with in_valid high and low otherwise, and out_data holds its value through cycles with in_valid low.
- R8: A synchronous active-high rst clears out_valid and out_data to 0.
- R9: Carries cross the internal slice boundary at bit 64, so in_a=2^64-1 gives out_data=10×(2^64-1) in plain mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are present this cycle |
| in_a | input | 128 | Unsigned operand to be scaled by ten |
| in_b | input | 128 | Source of the carry-in digit in bits 3:0 |
| in_ext | input | 1 | 1: add the carry-in digit |
| in_carry | input | 1 | 1: return the overflow digit, not the product |
| out_valid | output | 1 | out_data holds a new result |
| out_data | output | 128 | Product low bits or overflow digit |

## Verification
A wrong inter-slice carry shows up in the very next result as a corrupted upper half. It shows only for operands whose low half overflows, so the bench drives the boundary operand 2^64-1 and operands with all bits set. A fault in the digit clamp or in the mode mux shows up one clock after the bad input. It appears either as a carry digit above nine or as nonzero bits above bit 3, and the embedded properties flag these directly. A fault in the valid pipeline or in the hold logic shows on the first idle cycle, because the bench compares every output on every clock.

// File: rtl/qmt_pkg.sv
package qmt_pkg;

    localparam int unsigned DIG_W = 4;
    localparam logic [DIG_W-1:0] DIG_MAX = 4'd9;

    typedef struct packed {
        logic ext;
        logic carry;
    } qmt_mode_t;

    typedef struct packed {
        logic      valid;
        qmt_mode_t mode;
    } qmt_ctrl_t;

    function automatic logic [DIG_W-1:0] qmt_clamp_digit(input logic [DIG_W-1:0] d);
        return (d > DIG_MAX) ? '0 : d;
    endfunction

endpackage

// File: rtl/qmt_cin_sel.sv
module qmt_cin_sel
    import qmt_pkg::*;
(
    input  logic [DIG_W-1:0] b_digit,
    input  logic             ext,
    output logic [DIG_W-1:0] cin
);

    always_comb begin
        if (ext) begin
            cin = qmt_clamp_digit(b_digit);
        end else begin
            cin = '0;
        end
    end

    // R3, R6: the selected digit is a legal decimal digit
    always_comb begin
        a_r3_digit_legal: assert (cin <= DIG_MAX);
    end

endmodule

// File: rtl/qmt_x10_slice.sv
module qmt_x10_slice
    import qmt_pkg::*;
#(
    parameter int unsigned SW = 64
) (
    input  logic [SW-1:0]    a,
    input  logic [DIG_W-1:0] cin,
    output logic [SW-1:0]    prod,
    output logic [DIG_W-1:0] cout
);

    localparam int unsigned EW = SW + DIG_W;

    logic [EW-1:0] ext_a;
    logic [EW-1:0] sum;

    always_comb begin
        ext_a = {{DIG_W{1'b0}}, a};
        sum   = (ext_a << 3) + (ext_a << 1) + {{SW{1'b0}}, cin};
        prod  = sum[SW-1:0];
        cout  = sum[SW +: DIG_W];
    end

    // R5: a legal incoming digit yields a legal outgoing digit
    always_comb begin
        if (cin <= DIG_MAX) begin
            a_r5_slice_digit: assert (cout <= DIG_MAX);
        end
    end

endmodule

// File: rtl/qmt_result_sel.sv
module qmt_result_sel
    import qmt_pkg::*;
#(
    parameter int unsigned WIDTH = 128
) (
    input  logic [WIDTH-1:0] prod,
    input  logic [DIG_W-1:0] top_digit,
    input  logic             carry,
    output logic [WIDTH-1:0] data
);

    always_comb begin
        if (carry) begin
            data = {{(WIDTH-DIG_W){1'b0}}, top_digit};
        end else begin
            data = prod;
        end
    end

endmodule

// File: rtl/qmt_mul10.sv
module qmt_mul10
    import qmt_pkg::*;
#(
    parameter int unsigned WIDTH   = 128,
    parameter int unsigned SLICE_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic             in_ext,
    input  logic             in_carry,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data
);

    localparam int unsigned NSLICE = WIDTH / SLICE_W;

    qmt_ctrl_t        ctrl;
    logic [DIG_W-1:0] chain [NSLICE+1];
    logic [WIDTH-1:0] prod;
    logic [WIDTH-1:0] next_data;

    always_comb begin
        ctrl.valid      = in_valid;
        ctrl.mode.ext   = in_ext;
        ctrl.mode.carry = in_carry;
    end

    qmt_cin_sel u_cin (
        .b_digit (in_b[DIG_W-1:0]),
        .ext     (ctrl.mode.ext),
        .cin     (chain[0])
    );

    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        qmt_x10_slice #(.SW(SLICE_W)) u_slice (
            .a    (in_a[s*SLICE_W +: SLICE_W]),
            .cin  (chain[s]),
            .prod (prod[s*SLICE_W +: SLICE_W]),
            .cout (chain[s+1])
        );
    end

    qmt_result_sel #(.WIDTH(WIDTH)) u_res (
        .prod      (prod),
        .top_digit (chain[NSLICE]),
        .carry     (ctrl.mode.carry),
        .data      (next_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= ctrl.valid;
            if (ctrl.valid) begin
                out_data <= next_data;
            end
        end
    end

    // R7: valid follows the input by one clock
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r7_valid_drops: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r7_data_holds: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));
    // R4: carry modes leave every bit above the digit clear
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_carry) |=> (out_data[WIDTH-1:DIG_W] == '0));
    // R5: returned overflow digit is decimal
    a_r5_digit_max: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_carry) |=> (out_data[DIG_W-1:0] <= DIG_MAX));
    // R1: zero operand in plain mode gives zero
    a_r1_zero_in: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ext && !in_carry && in_a == '0) |=> (out_data == '0));
    // R8: reset clears the outputs
    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

endmodule

// File: tb/qmt_mul10_test.sv
module qmt_mul10_test;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] in_a;
    logic [127:0] in_b;
    logic         in_ext;
    logic         in_carry;
    logic         out_valid;
    logic [127:0] out_data;

    int checks   = 0;
    int failures = 0;
    logic [127:0] last_exp = '0;

    always #5 clk = ~clk;

    qmt_mul10 uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_ext(in_ext), .in_carry(in_carry), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                           input logic ext, input logic carry);
        logic [131:0] full;
        logic [3:0]   dig;
        dig  = (ext && b[3:0] <= 4'd9) ? b[3:0] : 4'd0;
        full = {4'b0, a} * 132'd10 + {128'b0, dig};
        return carry ? {124'b0, full[131:128]} : full[127:0];
    endfunction

    task automatic check(input string req, input logic v_exp, input logic [127:0] d_exp);
        checks++;
        if (out_valid !== v_exp || out_data !== d_exp) begin
            failures++;
            $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
                     req, out_valid, out_data, v_exp, d_exp);
        end
    endtask

    task automatic apply(input string req, input logic [127:0] a, input logic [127:0] b,
                         input logic ext, input logic carry);
        in_valid = 1'b1; in_a = a; in_b = b; in_ext = ext; in_carry = carry;
        last_exp = model(a, b, ext, carry);
        @(negedge clk);
        check(req, 1'b1, last_exp);
    endtask

    task automatic idle(input string req);
        in_valid = 1'b0; in_a = ~in_a; in_b = ~in_b; in_ext = ~in_ext;
        @(negedge clk);
        check(req, 1'b0, last_exp);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [127:0] ones;
        logic [127:0] lowmax;
        ones   = '1;
        lowmax = {64'd0, {64{1'b1}}};
        rst = 1'b1; in_valid = 1'b0; in_a = '0; in_b = '0; in_ext = 1'b0; in_carry = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 reset state", 1'b0, '0);
        rst = 1'b0;

        apply("R1 zero", '0, '0, 1'b0, 1'b0);
        apply("R1 small", 128'd12345, '0, 1'b0, 1'b0);
        apply("R1 all ones", ones, '0, 1'b0, 1'b0);
        apply("R9 slice boundary", lowmax, '0, 1'b0, 1'b0);
        apply("R9 boundary carry mode", lowmax, '0, 1'b0, 1'b1);
        apply("R2 digit 9", 128'd7, 128'd9, 1'b1, 1'b0);
        apply("R2 digit 9 boundary", lowmax, 128'h9, 1'b1, 1'b0);
        apply("R3 digit 15", 128'd7, 128'hF, 1'b1, 1'b0);
        apply("R3 digit 10", 128'd7, 128'hA, 1'b1, 1'b0);
        apply("R6 b ignored", 128'd7, 128'h5, 1'b0, 1'b0);
        apply("R6 b ignored carry", ones, 128'h9, 1'b0, 1'b1);
        apply("R4 all ones carry", ones, '0, 1'b0, 1'b1);
        apply("R5 all ones ext carry 9", ones, 128'h9, 1'b1, 1'b1);
        apply("R3 all ones ext carry 15", ones, 128'hF, 1'b1, 1'b1);
        apply("R4 zero carry", '0, 128'h9, 1'b1, 1'b1);
        idle("R7 hold after carry");
        idle("R7 second idle");
        apply("R7 back to back a", 128'd1, '0, 1'b0, 1'b0);
        apply("R7 back to back b", 128'd2, 128'd3, 1'b1, 1'b0);

        for (int i = 0; i < 400; i++) begin
            logic [1:0] m;
            m = i[1:0];
            case (m)
                2'd0: apply("R1 random plain", rnd128(), rnd128(), 1'b0, 1'b0);
                2'd1: apply("R2 random ext", rnd128(), rnd128(), 1'b1, 1'b0);
                2'd2: apply("R4 random carry", rnd128(), rnd128(), 1'b0, 1'b1);
                default: apply("R5 random ext carry", rnd128(), rnd128(), 1'b1, 1'b1);
            endcase
            if (i % 7 == 0) idle("R7 random idle");
        end

        in_valid = 1'b1; in_a = ones; in_ext = 1'b0; in_carry = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R8 reset mid run", 1'b0, '0);
        rst = 1'b0; in_valid = 1'b0;
        last_exp = '0;
        @(negedge clk);
        check("R8 after reset idle", 1'b0, '0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule